// File: doc/BRIEF.md
# Interrupt Redirection Router with Level Acknowledge

The block sits between a set of interrupt request pins and the message fabric that carries interrupts to processors. Each pin owns a 64-bit redirection entry that software programs through a simple index/data port. The entry fixes the vector, delivery mode, destination mode, destination, input polarity, trigger mode and mask. Pin activity is latched into a request register. The router turns each unmasked pending request into one interrupt message on a valid/ready interface.

Edge-triggered pins are consumed when delivered. A level-triggered pin instead raises a remote-pending flag in its entry when delivered, and the flag stops any further delivery from that pin. The flag is dropped when the processor side broadcasts an end-of-interrupt whose vector equals the entry's vector. If the line is still active at that point, the pin is delivered again. This keeps an interrupt source that stays asserted from being lost or from flooding the fabric.

Top module: `irq_redirect`

## Requirements
- R1: After reset no message is pending. Every entry reads back with only the mask bit (bit 16) set, and all request and remote-pending state is clear.
- R2: The entry layout is: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, polarity in 13 (1 = active low), remote-pending in 14, trigger mode in 15 (0 = edge, 1 = level), mask in 16 and destination in 63:56. A message carries the vector, delivery mode, destination mode, destination and trigger mode of the delivered pin, along with the pin number.
- R3: A write at an index below the pin count replaces the whole entry except bit 14. Bit 14 always reads back the remote-pending state. A read returns the entry at the current index in the same cycle. Writes at an index at or above the pin count are ignored, and reads at such an index return zero.
- R4: The request bit of a level pin follows the polarity-adjusted pin level one cycle later. The request bit of an edge pin is set on an inactive-to-active transition of the polarity-adjusted level.
- R5: A pin whose mask bit is set is never delivered. Its request bit is still latched, so it is delivered once the pin is unmasked.
- R6: Delivering an edge pin clears its request bit, so each active edge yields exactly one message.
- R7: Delivering a level pin sets its remote-pending bit and leaves its request bit alone. While remote-pending is set, that pin is not delivered.
- R8: An end-of-interrupt broadcast clears remote-pending on every entry whose vector equals the broadcast vector. Entries with a different vector keep their remote-pending bit.
- R9: Once remote-pending clears on an unmasked level pin whose line is still active, the pin is delivered again.
- R10: At most one message is loaded per cycle, and it comes from the lowest-numbered eligible pin. A message not yet accepted stays valid and unchanged until the ready input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Interrupt request pins |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_idx_i | input | IDX_W | Entry index for read and write |
| cfg_wdata_i | input | 64 | Entry write data |
| cfg_rdata_o | output | 64 | Entry read data at cfg_idx_i |
| eoi_valid_i | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector_i | input | 8 | Vector of the broadcast |
| msg_valid_o | output | 1 | Interrupt message valid |
| msg_ready_i | input | 1 | Message accepted by the fabric |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_dstmode_o | output | 1 | Message destination mode |
| msg_dest_o | output | 8 | Message destination |
| msg_trig_o | output | 1 | Trigger mode of the delivered pin |
| msg_pin_o | output | IDX_W | Pin number of the delivered request |

## Verification
The bench builds the router with its defaults: 24 pins and a 5-bit index. With a 5-bit index, indices 24 to 31 can be driven, so the ignored writes and zero reads outside the pin range can be tested. The random phase draws vectors from a pool of four values. Broadcasts therefore often match several level entries at once, and they often arrive in the same cycle as a delivery or an entry rewrite on the same pin. Ready is held low for stretches, which lets several eligible pins queue up behind a stalled message.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;
  localparam int ENTRY_W  = 64;
  localparam int VEC_W    = 8;
  localparam int DM_LSB   = 8;
  localparam int DSTM_BIT = 11;
  localparam int POL_BIT  = 13;
  localparam int RPND_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int DEST_LSB = 56;

  localparam logic [ENTRY_W-1:0] ENTRY_RST  = ENTRY_W'(1) << MASK_BIT;
  localparam logic [ENTRY_W-1:0] RPND_MASK  = ENTRY_W'(1) << RPND_BIT;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] dmode;
    logic       dstmode;
    logic [7:0] dest;
    logic       trig;
  } msg_t;

  function automatic msg_t entry_to_msg(input logic [ENTRY_W-1:0] e);
    msg_t m;
    m.vector  = e[VEC_W-1:0];
    m.dmode   = e[DM_LSB+:3];
    m.dstmode = e[DSTM_BIT];
    m.dest    = e[DEST_LSB+:8];
    m.trig    = e[TRIG_BIT];
    return m;
  endfunction
endpackage

// File: rtl/rr_entry_bank.sv
module rr_entry_bank
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [ENTRY_W-1:0]  wdata_i,
  input  logic [NUM_PINS-1:0] set_rpnd_i,
  input  logic                eoi_valid_i,
  input  logic [VEC_W-1:0]    eoi_vec_i,
  output logic [ENTRY_W-1:0]  entry_o [NUM_PINS]
);
  logic [ENTRY_W-1:0]  cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] rpnd_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
    logic eoi_hit;
    assign eoi_hit = eoi_valid_i && rpnd_q[p] && (cfg_q[p][VEC_W-1:0] == eoi_vec_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[p] <= ENTRY_RST;
      end else if (we_i && idx_i == IDX_W'(p)) begin
        cfg_q[p] <= wdata_i & ~RPND_MASK;
      end
    end

    // delivery set wins over a same-cycle acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            rpnd_q[p] <= 1'b0;
      else if (set_rpnd_i[p]) rpnd_q[p] <= 1'b1;
      else if (eoi_hit)       rpnd_q[p] <= 1'b0;
    end

    assign entry_o[p] = cfg_q[p] | (ENTRY_W'(rpnd_q[p]) << RPND_BIT);
  end
endmodule

// File: rtl/rr_irr.sv
module rr_irr #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] irr_o
);
  logic [NUM_PINS-1:0] act, prev_q, irr_q;

  assign act = pin_i ^ pol_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_irr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           irr_q[p] <= 1'b0;
      else if (trig_i[p])    irr_q[p] <= act[p];
      else if (act[p] && !prev_q[p]) irr_q[p] <= 1'b1;
      else if (clr_i[p])     irr_q[p] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= act;
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [NUM_PINS-1:0] req_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [63:0]         cfg_wdata_i,
  output logic [63:0]         cfg_rdata_o,
  input  logic                eoi_valid_i,
  input  logic [7:0]          eoi_vector_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [2:0]          msg_dmode_o,
  output logic                msg_dstmode_o,
  output logic [7:0]          msg_dest_o,
  output logic                msg_trig_o,
  output logic [IDX_W-1:0]    msg_pin_o
);
  logic [ENTRY_W-1:0]  entry [NUM_PINS];
  logic [NUM_PINS-1:0] pol_v, trig_v, mask_v, rpnd_v, irr_v, elig_v, deliver_oh;
  logic [NUM_PINS*VEC_W-1:0] vec_flat;
  logic                found, load;
  logic [IDX_W-1:0]    sel;
  logic                valid_q;
  msg_t                msg_q;
  logic [IDX_W-1:0]    pin_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_split
    assign pol_v[p]  = entry[p][POL_BIT];
    assign trig_v[p] = entry[p][TRIG_BIT];
    assign mask_v[p] = entry[p][MASK_BIT];
    assign rpnd_v[p] = entry[p][RPND_BIT];
    assign vec_flat[p*VEC_W+:VEC_W] = entry[p][VEC_W-1:0];
  end

  rr_entry_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .idx_i       (cfg_idx_i),
    .wdata_i     (cfg_wdata_i),
    .set_rpnd_i  (deliver_oh & trig_v),
    .eoi_valid_i (eoi_valid_i),
    .eoi_vec_i   (eoi_vector_i),
    .entry_o     (entry)
  );

  rr_irr #(.NUM_PINS(NUM_PINS)) u_irr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .pol_i  (pol_v),
    .trig_i (trig_v),
    .clr_i  (deliver_oh),
    .irr_o  (irr_v)
  );

  // a level pin waiting for acknowledge is held off
  assign elig_v = irr_v & ~mask_v & ~(trig_v & rpnd_v);

  rr_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .req_i   (elig_v),
    .found_o (found),
    .idx_o   (sel)
  );

  assign load       = found && (!valid_q || msg_ready_i);
  assign deliver_oh = load ? (NUM_PINS'(1) << sel) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
      pin_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      msg_q   <= entry_to_msg(entry[sel]);
      pin_q   <= sel;
    end else if (msg_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  logic             rd_ok;
  logic [IDX_W-1:0] rd_idx;
  assign rd_ok       = (32'(cfg_idx_i) < NUM_PINS);
  assign rd_idx      = rd_ok ? cfg_idx_i : '0;
  assign cfg_rdata_o = rd_ok ? entry[rd_idx] : '0;

  assign msg_valid_o   = valid_q;
  assign msg_vector_o  = msg_q.vector;
  assign msg_dmode_o   = msg_q.dmode;
  assign msg_dstmode_o = msg_q.dstmode;
  assign msg_dest_o    = msg_q.dest;
  assign msg_trig_o    = msg_q.trig;
  assign msg_pin_o     = pin_q;
endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      msg_valid,
  input logic                      msg_ready,
  input logic [IDX_W+20:0]         payload,
  input logic                      load,
  input logic [IDX_W-1:0]          sel,
  input logic [NUM_PINS-1:0]       mask_v,
  input logic [NUM_PINS-1:0]       trig_v,
  input logic [NUM_PINS-1:0]       rpnd_v,
  input logic [NUM_PINS*8-1:0]     vec_flat,
  input logic                      eoi_valid,
  input logic [7:0]                eoi_vec
);
  logic [NUM_PINS-1:0] hit, set_oh;
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++)
      hit[p] = eoi_valid && rpnd_v[p] && (vec_flat[p*8+:8] == eoi_vec);
  end
  assign set_oh = load ? (NUM_PINS'(1) << sel) : '0;

  assert_hold_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid && !msg_ready |=> msg_valid && $stable(payload));

  assert_no_masked_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> !mask_v[sel]);

  assert_level_sets_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && trig_v[sel] |=> rpnd_v[$past(sel)]);

  assert_pending_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> !(trig_v[sel] && rpnd_v[sel]));

  assert_eoi_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid |=> (rpnd_v & $past(hit & ~set_oh)) == '0);
endmodule

bind irq_redirect irq_redirect_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .msg_valid (msg_valid_o),
  .msg_ready (msg_ready_i),
  .payload   ({msg_vector_o, msg_dmode_o, msg_dstmode_o, msg_dest_o, msg_trig_o, msg_pin_o}),
  .load      (load),
  .sel       (sel),
  .mask_v    (mask_v),
  .trig_v    (trig_v),
  .rpnd_v    (rpnd_v),
  .vec_flat  (vec_flat),
  .eoi_valid (eoi_valid_i),
  .eoi_vec   (eoi_vector_i)
);

// File: tb/tb_irq_redirect.sv
module tb_irq_redirect;
  localparam int N  = 24;
  localparam int IW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  pin;
  logic          we;
  logic [IW-1:0] idx;
  logic [63:0]   wdata, rdata;
  logic          eoi_v;
  logic [7:0]    eoi_vec;
  logic          mvalid, mready;
  logic [7:0]    mvec, mdest;
  logic [2:0]    mdm;
  logic          mdstm, mtrig;
  logic [IW-1:0] mpin;

  irq_redirect #(.NUM_PINS(N), .IDX_W(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec),
    .msg_valid_o(mvalid), .msg_ready_i(mready), .msg_vector_o(mvec), .msg_dmode_o(mdm),
    .msg_dstmode_o(mdstm), .msg_dest_o(mdest), .msg_trig_o(mtrig), .msg_pin_o(mpin)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";

  logic [63:0] m_ent [N];
  logic [N-1:0] m_irr, m_prev;
  logic        m_mv;
  logic [63:0] m_ment;
  int          m_mpin;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < N; p++) m_ent[p] = 64'h1 << 16;
    m_irr = '0; m_prev = '0; m_mv = 1'b0; m_ment = '0; m_mpin = 0;
  endtask

  task automatic model_step();
    logic [N-1:0] act, rdy, n_irr;
    logic [63:0]  n_ent [N];
    int sel; bit ld, rem;
    sel = -1;
    for (int p = 0; p < N; p++) begin
      act[p] = pin[p] ^ m_ent[p][13];
      rdy[p] = m_irr[p] & !m_ent[p][16] & !(m_ent[p][15] & m_ent[p][14]);
    end
    for (int p = N - 1; p >= 0; p--) if (rdy[p]) sel = p;
    ld = (sel >= 0) && (!m_mv || mready);
    for (int p = 0; p < N; p++) begin
      if (m_ent[p][15]) n_irr[p] = act[p];
      else n_irr[p] = (act[p] & !m_prev[p]) | (m_irr[p] & !(ld && sel == p));
      rem = m_ent[p][14];
      if (ld && sel == p && m_ent[p][15]) rem = 1'b1;
      else if (eoi_v && rem && m_ent[p][7:0] == eoi_vec) rem = 1'b0;
      n_ent[p] = m_ent[p];
      n_ent[p][14] = rem;
    end
    if (we && int'(idx) < N) begin
      rem = n_ent[idx][14];
      n_ent[idx] = wdata;
      n_ent[idx][14] = rem;
    end
    if (ld) begin m_mv = 1'b1; m_ment = m_ent[sel]; m_mpin = sel; end
    else if (mready) m_mv = 1'b0;
    for (int p = 0; p < N; p++) m_ent[p] = n_ent[p];
    m_irr = n_irr;
    m_prev = act;
  endtask

  task automatic compare();
    logic [63:0] exp_rd;
    exp_rd = (int'(idx) < N) ? m_ent[idx] : 64'h0;
    check(rdata == exp_rd, cur_req, "entry readback", rdata, exp_rd);
    check(mvalid == m_mv, cur_req, "msg valid", 64'(mvalid), 64'(m_mv));
    if (m_mv) begin
      check(int'(mpin) == m_mpin, cur_req, "msg pin", 64'(mpin), 64'(m_mpin));
      check({mvec, mdm, mdstm, mdest, mtrig} ==
            {m_ment[7:0], m_ment[10:8], m_ment[11], m_ment[63:56], m_ment[15]},
            "R2", "msg fields", 64'({mvec, mdm, mdstm, mdest, mtrig}),
            64'({m_ment[7:0], m_ment[10:8], m_ment[11], m_ment[63:56], m_ment[15]}));
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    we = 1'b0;
    eoi_v = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  function automatic logic [63:0] mk(input logic [7:0] v, input logic [7:0] d, input bit lvl,
                                     input bit pol, input bit msk);
    return {d, 39'h0, msk, lvl, 1'b0, pol, 1'b0, 1'b1, 3'd5, v};
  endfunction

  task automatic wr(input int i, input logic [63:0] e);
    we = 1'b1; idx = IW'(i); wdata = e;
    cycle();
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_v = 1'b1; eoi_vec = v;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; pin = '0; we = 1'b0; idx = '0; wdata = '0;
    eoi_v = 1'b0; eoi_vec = '0; mready = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    compare();
    check(rdata == 64'h1_0000, "R1", "reset entry", rdata, 64'h1_0000);

    // R3: write/readback, pending bit not writable, out of range ignored
    cur_req = "R3";
    wr(3, mk(8'h41, 8'h5A, 1'b0, 1'b0, 1'b0) | (64'h1 << 14));
    check(rdata == mk(8'h41, 8'h5A, 1'b0, 1'b0, 1'b0), "R3", "readback", rdata,
          mk(8'h41, 8'h5A, 1'b0, 1'b0, 1'b0));
    wr(28, 64'hFFFF_FFFF_FFFF_FFFF);
    check(rdata == 64'h0, "R3", "out of range read", rdata, 64'h0);

    // R6: one edge, one message
    cur_req = "R6";
    idx = 3; pin[3] = 1'b1; run(6);
    pin[3] = 1'b0; run(2);

    // R5: masked edge pin latched but held, then unmasked
    cur_req = "R5";
    wr(4, mk(8'h42, 8'h11, 1'b0, 1'b0, 1'b1));
    pin[4] = 1'b1; run(6);
    wr(4, mk(8'h42, 8'h11, 1'b0, 1'b0, 1'b0)); run(4);

    // R4/R7: active-low level pin delivered once, remote-pending set
    cur_req = "R4";
    pin[6] = 1'b1;
    wr(6, mk(8'h60, 8'h22, 1'b1, 1'b1, 1'b0));
    pin[6] = 1'b0; run(5);
    cur_req = "R7";
    idx = 6; run(4);
    check(rdata[14] == 1'b1, "R7", "pending bit", 64'(rdata[14]), 64'h1);

    // R8: mismatched acknowledge keeps pending
    cur_req = "R8";
    eoi(8'h61); run(2);
    check(rdata[14] == 1'b1, "R8", "pending kept", 64'(rdata[14]), 64'h1);

    // R9: matching acknowledge with line still active re-delivers
    cur_req = "R9";
    eoi(8'h60); run(4);
    check(rdata[14] == 1'b1, "R9", "pending again", 64'(rdata[14]), 64'h1);
    pin[6] = 1'b1; eoi(8'h60); run(3);
    check(rdata[14] == 1'b0, "R9", "no re-delivery", 64'(rdata[14]), 64'h0);

    // R10: stall, queue pins 9 and 8, lowest first
    cur_req = "R10";
    wr(8, mk(8'h80, 8'h33, 1'b0, 1'b0, 1'b0));
    wr(9, mk(8'h90, 8'h44, 1'b0, 1'b0, 1'b0));
    pin[3] = 1'b1; run(3);
    mready = 1'b0; pin[9] = 1'b1; pin[8] = 1'b1; run(5);
    mready = 1'b1; run(6);

    // random mix
    cur_req = "R2";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 6 == 0) pin[$urandom % N] ^= 1'b1;
      mready = ($urandom % 4) != 0;
      idx = IW'($urandom % 32);
      if ($urandom % 10 == 0) begin
        we = 1'b1;
        wdata = {$urandom, $urandom};
        wdata[7:0] = 8'h30 + 8'($urandom % 4);
        wdata[16] = ($urandom % 4) == 0;
      end
      if ($urandom % 8 == 0) begin
        eoi_v = 1'b1; eoi_vec = 8'h30 + 8'($urandom % 4);
      end
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule